// File: doc/BRIEF.md
# Vectored Priority Interrupt Arbiter

This block arbitrates interrupt requests for a small 8-bit processor core. It takes a set of request lines and a non-maskable reset request. Each request is latched into a pending bit. A pending source becomes eligible when its own enable bit and a global enable flag are both one. The arbiter then presents the eligible source with the lowest vector address as a registered valid/vector pair. The vector is the source's slot index multiplied by the slot size. The reset vector sits in slot 0, and request line `irq_req[k]` uses slot `k+1`.

The processor accepts the presented vector by pulsing `irq_ack`. On that same clock edge, the accepted pending bit is cleared and the global enable flag drops, so no other request is presented while the handler runs. Software can raise the flag again from inside a handler, and any eligible request then pre-empts the handler. A return-from-interrupt strobe restores the flag automatically. A reset request overrides the flag and the enable mask, and it clears both.

Top module: `irq_vector_arbiter`

## Requirements
- R1: After `rst_n` is released, `irq_valid`, `irq_vector`, `gie` and `irq_mask` all read zero.
- R2: Request line `irq_req[k]` is presented only while enable bit `irq_mask[k]` and `gie` are both one. The presented vector is then `(k+1)*SLOT_WORDS`.
- R3: When several sources are eligible, the lowest slot index is presented. `irq_req[0]` is outranked only by the reset request.
- R4: A request that is high at a clock edge sets a pending bit. That bit stays set until the source is acknowledged, so a lower-priority source is still presented after a higher one is served.
- R5: `irq_ack` while `irq_valid` is high clears the presented source's pending bit and `gie` on the same edge. After that edge `irq_valid` is low unless a reset request is pending.
- R6: `gie_set` sets `gie`. Any eligible pending source is presented right after that same edge.
- R7: `reti` sets `gie` to one, and the highest eligible pending source is presented right after that edge.
- R8: `sys_rst_req` presents vector 0 with `irq_valid` high, whatever the mask or `gie` hold. It also clears `irq_mask` and `gie`. It stays presented, with mask and flag held at zero, until acknowledged.
- R9: A new request that is eligible at a clock edge appears on `irq_valid`/`irq_vector` right after that same edge. A newly arrived higher-priority request replaces a lower one that has not been acknowledged.
- R10: `irq_ack` while `irq_valid` is low changes neither `gie` nor any pending state.
- R11: When several flag updates coincide, the precedence is: reset request first, then acceptance, then `gie_clr`, then `gie_set`/`reti`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sys_rst_req | input | 1 | Non-maskable reset request, slot 0 |
| irq_req | input | NUM_SRC | Request lines; bit k uses slot k+1 |
| mask_we | input | 1 | Write strobe for the enable mask |
| mask_wdata | input | NUM_SRC | New enable mask value |
| gie_set | input | 1 | Software sets the global enable flag |
| gie_clr | input | 1 | Software clears the global enable flag |
| reti | input | 1 | Return-from-interrupt strobe |
| irq_ack | input | 1 | Processor accepts the presented vector |
| irq_valid | output | 1 | A vector is being presented |
| irq_vector | output | VEC_W | Presented vector address (zero when idle) |
| gie | output | 1 | Global enable flag |
| irq_mask | output | NUM_SRC | Current enable mask |

## Verification
A corrupted pending bit or a wrong flag shows up at the ports within one clock edge. The vector presented after the next `gie_set`, `reti` or acknowledge is either the wrong one or missing. A pending bit that is lost is exposed when a higher-priority source is acknowledged and the lower one fails to appear afterwards. A pending bit that is never cleared is exposed when the same vector reappears after `reti`. Reset handling is visible on the first edge after the request, through `irq_mask` and `gie`.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  // Vector address of a slot: index scaled by the slot size in words.
  function automatic int unsigned slot_addr(input int unsigned idx, input int unsigned slot_words);
    return idx * slot_words;
  endfunction
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/irq_pending_bank.sv
module irq_pending_bank #(
  parameter int unsigned WIDTH = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] set_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] pend_d,
  output logic [WIDTH-1:0] pend_q
);
  // Clear wins over a new request in the same cycle; a held line re-pends next edge.
  always_comb begin
    pend_d = (pend_q | set_i) & ~clr_i;
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic bit_en;
    assign bit_en = set_i[i] | clr_i[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pend_q[i] <= 1'b0;
      else if (bit_en) pend_q[i] <= pend_d[i];
    end

    // R4: a pending bit is only dropped by a clear for that bit
    assert_pending_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q[i] && !clr_i[i]) |=> pend_q[i]);
  end
endmodule

// File: rtl/irq_prio_encoder.sv
module irq_prio_encoder #(
  parameter int unsigned WIDTH = 9,
  localparam int unsigned IW   = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic [WIDTH-1:0] req_i,
  output logic             any_o,
  output logic [WIDTH-1:0] gnt_o,
  output logic [IW-1:0]    idx_o
);
  logic [WIDTH:0] below;   // below[i]: some request at an index lower than i

  assign below[0] = 1'b0;
  for (genvar i = 0; i < WIDTH; i++) begin : g_chain
    assign below[i+1] = below[i] | req_i[i];
    assign gnt_o[i]   = req_i[i] & ~below[i];
  end

  assign any_o = below[WIDTH];

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < WIDTH; i++) begin
      if (gnt_o[i]) idx_o = idx_o | IW'(i);
    end
  end
endmodule

// File: rtl/irq_gie_ctrl.sv
module irq_gie_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic force_clr_i,
  input  logic accept_i,
  input  logic sw_clr_i,
  input  logic sw_set_i,
  input  logic reti_i,
  output logic gie_d,
  output logic gie_q
);
  logic gie_en;

  always_comb begin
    if (force_clr_i)              gie_d = 1'b0;
    else if (accept_i)            gie_d = 1'b0;
    else if (sw_clr_i)            gie_d = 1'b0;
    else if (sw_set_i || reti_i)  gie_d = 1'b1;
    else                          gie_d = gie_q;
  end

  assign gie_en = force_clr_i | accept_i | sw_clr_i | sw_set_i | reti_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      gie_q <= 1'b0;
    else if (gie_en) gie_q <= gie_d;
  end

  // R7: return restores the flag when nothing stronger coincides
  assert_reti_restores_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reti_i && !force_clr_i && !accept_i && !sw_clr_i) |=> gie_q);
  // R11: acceptance beats a same-cycle set or return
  assert_accept_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    accept_i |=> !gie_q);
endmodule

// File: rtl/irq_vector_arbiter.sv
module irq_vector_arbiter #(
  parameter int unsigned NUM_SRC    = 8,
  parameter int unsigned SLOT_WORDS = 2,
  parameter int unsigned VEC_W      = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sys_rst_req,
  input  logic [NUM_SRC-1:0] irq_req,
  input  logic               mask_we,
  input  logic [NUM_SRC-1:0] mask_wdata,
  input  logic               gie_set,
  input  logic               gie_clr,
  input  logic               reti,
  input  logic               irq_ack,
  output logic               irq_valid,
  output logic [VEC_W-1:0]   irq_vector,
  output logic               gie,
  output logic [NUM_SRC-1:0] irq_mask
);
  import irq_arb_pkg::*;

  localparam int unsigned SLOTS = NUM_SRC + 1;
  localparam int unsigned IW    = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  logic               srst_n;
  logic [SLOTS-1:0]   pend_set, pend_clr, pend_d, pend_q;
  logic [SLOTS-1:0]   elig, gnt_d, gnt_q;
  logic [IW-1:0]      idx_d;
  logic               any_d, valid_q;
  logic [VEC_W-1:0]   vec_d, vec_q;
  logic [NUM_SRC-1:0] mask_d, mask_q;
  logic               mask_en, force_clr, accept, gie_d, gie_q;

  irq_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  // Slot 0 is the reset request; slot k+1 is irq_req[k].
  assign accept    = irq_ack & valid_q;
  assign force_clr = sys_rst_req | pend_q[0];
  assign pend_set  = {irq_req, sys_rst_req};
  assign pend_clr  = accept ? gnt_q : '0;

  irq_pending_bank #(.WIDTH(SLOTS)) u_pend (
    .clk    (clk),
    .rst_n  (srst_n),
    .set_i  (pend_set),
    .clr_i  (pend_clr),
    .pend_d (pend_d),
    .pend_q (pend_q)
  );

  irq_gie_ctrl u_gie (
    .clk         (clk),
    .rst_n       (srst_n),
    .force_clr_i (force_clr),
    .accept_i    (accept),
    .sw_clr_i    (gie_clr),
    .sw_set_i    (gie_set),
    .reti_i      (reti),
    .gie_d       (gie_d),
    .gie_q       (gie_q)
  );

  // Enable mask: reset request wipes it, otherwise software write.
  always_comb begin
    if (force_clr)    mask_d = '0;
    else if (mask_we) mask_d = mask_wdata;
    else              mask_d = mask_q;
  end
  assign mask_en = force_clr | mask_we;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)      mask_q <= '0;
    else if (mask_en) mask_q <= mask_d;
  end

  // Eligibility from next-state values so the presentation never lags an ack.
  assign elig = pend_d & {mask_d & {NUM_SRC{gie_d}}, 1'b1};

  irq_prio_encoder #(.WIDTH(SLOTS)) u_enc (
    .req_i (elig),
    .any_o (any_d),
    .gnt_o (gnt_d),
    .idx_o (idx_d)
  );

  always_comb begin
    vec_d = '0;
    if (any_d) vec_d = VEC_W'(slot_addr(int'(idx_d), SLOT_WORDS));
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      valid_q <= 1'b0;
      gnt_q   <= '0;
      vec_q   <= '0;
    end else begin
      valid_q <= any_d;
      gnt_q   <= gnt_d;
      vec_q   <= vec_d;
    end
  end

  assign irq_valid  = valid_q;
  assign irq_vector = vec_q;
  assign gie        = gie_q;
  assign irq_mask   = mask_q;

  // R2: a maskable slot is only presented with the flag and its enable set
  assert_gated_by_flag_R2: assert property (@(posedge clk) disable iff (!srst_n)
    (valid_q && !gnt_q[0]) |-> (gie_q && |(gnt_q[SLOTS-1:1] & mask_q)));
  // R3: exactly one slot is granted while presenting
  assert_single_grant_R3: assert property (@(posedge clk) disable iff (!srst_n)
    valid_q |-> $onehot(gnt_q));
  // R5: acceptance drops the flag on the same edge
  assert_ack_clears_flag_R5: assert property (@(posedge clk) disable iff (!srst_n)
    accept |=> !gie_q);
  // R8: reset request forces vector 0 and clears mask and flag
  assert_reset_vector_R8: assert property (@(posedge clk) disable iff (!srst_n)
    sys_rst_req |=> (valid_q && vec_q == '0 && mask_q == '0 && !gie_q));
  // R10: an acknowledge with nothing presented leaves the flag alone
  assert_idle_ack_R10: assert property (@(posedge clk) disable iff (!srst_n)
    (irq_ack && !valid_q && !sys_rst_req && !pend_q[0] && !gie_set && !gie_clr && !reti)
      |=> $stable(gie_q));
endmodule

// File: tb/irq_vector_arbiter_test.sv
module irq_vector_arbiter_test;
  localparam int unsigned NS   = 8;
  localparam int unsigned SLOT = 2;
  localparam int unsigned VW   = 8;

  typedef struct packed {
    logic          srst;
    logic          mwe;
    logic [NS-1:0] mdat;
    logic [NS-1:0] req;
    logic          set;
    logic          clr;
    logic          ret;
    logic          ack;
    logic          ev;
    logic [VW-1:0] evec;
    logic          egie;
    logic [3:0]    rq;
  } row_t;

  localparam int NROWS = 22;
  // srst mwe mdat req set clr reti ack | valid vector gie | req#
  localparam row_t ROWS [NROWS] = '{
    '{1'b0,1'b0,8'h00,8'h00,1'b0,1'b0,1'b0,1'b0, 1'b0,8'd0, 1'b0,4'd1 },  // R1 idle
    '{1'b0,1'b1,8'hFF,8'h00,1'b0,1'b0,1'b0,1'b0, 1'b0,8'd0, 1'b0,4'd2 },  // R2 mask only
    '{1'b0,1'b0,8'h00,8'h14,1'b0,1'b0,1'b0,1'b0, 1'b0,8'd0, 1'b0,4'd2 },  // R2 flag low
    '{1'b0,1'b0,8'h00,8'h00,1'b1,1'b0,1'b0,1'b0, 1'b1,8'd6, 1'b1,4'd6 },  // R6 R3 bit2 wins
    '{1'b0,1'b0,8'h00,8'h00,1'b0,1'b0,1'b0,1'b1, 1'b0,8'd0, 1'b0,4'd5 },  // R5 accept
    '{1'b0,1'b0,8'h00,8'h00,1'b1,1'b0,1'b0,1'b0, 1'b1,8'd10,1'b1,4'd4 },  // R4 bit4 still pending
    '{1'b0,1'b0,8'h00,8'h01,1'b0,1'b0,1'b0,1'b0, 1'b1,8'd2, 1'b1,4'd9 },  // R9 pre-empts
    '{1'b0,1'b0,8'h00,8'h00,1'b0,1'b0,1'b0,1'b1, 1'b0,8'd0, 1'b0,4'd5 },  // R5 accept bit0
    '{1'b0,1'b0,8'h00,8'h00,1'b0,1'b0,1'b1,1'b0, 1'b1,8'd10,1'b1,4'd7 },  // R7 return
    '{1'b0,1'b0,8'h00,8'h00,1'b0,1'b0,1'b0,1'b1, 1'b0,8'd0, 1'b0,4'd5 },  // R5 accept bit4
    '{1'b0,1'b0,8'h00,8'h00,1'b0,1'b0,1'b1,1'b0, 1'b0,8'd0, 1'b1,4'd7 },  // R7 return, idle
    '{1'b0,1'b0,8'h00,8'h00,1'b0,1'b0,1'b0,1'b1, 1'b0,8'd0, 1'b1,4'd10},  // R10 idle ack
    '{1'b0,1'b1,8'hFE,8'h01,1'b0,1'b0,1'b0,1'b0, 1'b0,8'd0, 1'b1,4'd2 },  // R2 bit0 masked
    '{1'b0,1'b0,8'h00,8'h80,1'b0,1'b0,1'b0,1'b0, 1'b1,8'd16,1'b1,4'd2 },  // R2 bit7
    '{1'b0,1'b1,8'hFF,8'h00,1'b0,1'b0,1'b0,1'b0, 1'b1,8'd2, 1'b1,4'd3 },  // R3 bit0 unmasked
    '{1'b0,1'b0,8'h00,8'h00,1'b0,1'b1,1'b0,1'b0, 1'b0,8'd0, 1'b0,4'd11},  // R11 clear
    '{1'b0,1'b0,8'h00,8'h00,1'b1,1'b1,1'b0,1'b0, 1'b0,8'd0, 1'b0,4'd11},  // R11 clr beats set
    '{1'b1,1'b0,8'h00,8'h00,1'b0,1'b0,1'b0,1'b0, 1'b1,8'd0, 1'b0,4'd8 },  // R8 reset request
    '{1'b0,1'b0,8'h00,8'h00,1'b1,1'b0,1'b0,1'b0, 1'b1,8'd0, 1'b0,4'd8 },  // R8 holds flag low
    '{1'b0,1'b0,8'h00,8'h00,1'b0,1'b0,1'b0,1'b1, 1'b0,8'd0, 1'b0,4'd8 },  // R8 acked
    '{1'b0,1'b1,8'h80,8'h00,1'b1,1'b0,1'b0,1'b0, 1'b1,8'd16,1'b1,4'd8 },  // R8 mask was wiped
    '{1'b0,1'b0,8'h00,8'h00,1'b0,1'b0,1'b1,1'b1, 1'b0,8'd0, 1'b0,4'd11}   // R11 ack beats reti
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sys_rst_req = 1'b0;
  logic [NS-1:0] irq_req = '0;
  logic          mask_we = 1'b0;
  logic [NS-1:0] mask_wdata = '0;
  logic          gie_set = 1'b0, gie_clr = 1'b0, reti = 1'b0, irq_ack = 1'b0;
  logic          irq_valid, gie;
  logic [VW-1:0] irq_vector;
  logic [NS-1:0] irq_mask;

  int applied = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  irq_vector_arbiter #(.NUM_SRC(NS), .SLOT_WORDS(SLOT), .VEC_W(VW)) uut (
    .clk(clk), .rst_n(rst_n), .sys_rst_req(sys_rst_req), .irq_req(irq_req),
    .mask_we(mask_we), .mask_wdata(mask_wdata), .gie_set(gie_set), .gie_clr(gie_clr),
    .reti(reti), .irq_ack(irq_ack), .irq_valid(irq_valid), .irq_vector(irq_vector),
    .gie(gie), .irq_mask(irq_mask)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    applied++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input row_t r);
    @(negedge clk);
    sys_rst_req = r.srst; mask_we = r.mwe; mask_wdata = r.mdat; irq_req = r.req;
    gie_set = r.set; gie_clr = r.clr; reti = r.ret; irq_ack = r.ack;
    @(posedge clk);
    #2;
    sys_rst_req = 1'b0; mask_we = 1'b0; irq_req = '0;
    gie_set = 1'b0; gie_clr = 1'b0; reti = 1'b0; irq_ack = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  function automatic row_t idle_row();
    row_t r;
    r = '0;
    return r;
  endfunction

  initial begin
    row_t r;
    do_reset();
    // R1: reset state at the ports
    check("R1 valid", 32'(irq_valid), 32'd0);
    check("R1 vector", 32'(irq_vector), 32'd0);
    check("R1 gie", 32'(gie), 32'd0);
    check("R1 mask", 32'(irq_mask), 32'd0);

    for (int i = 0; i < NROWS; i++) begin
      drive(ROWS[i]);
      check($sformatf("R%0d row%0d", ROWS[i].rq, i),
            {irq_valid, irq_vector, gie}, {ROWS[i].ev, ROWS[i].evec, ROWS[i].egie});
    end

    // R8: mask readback after the reset-request sequence
    check("R8 mask", 32'(irq_mask), 32'h80);

    // R1: rst_n mid-operation returns everything to zero
    r = idle_row(); r.set = 1'b1; r.req = 8'h80; drive(r);
    do_reset();
    check("R1 valid after rst_n", 32'(irq_valid), 32'd0);
    check("R1 gie/mask after rst_n", {gie, irq_mask}, 32'd0);

    // R4: a held request re-pends after acknowledge and reappears on return
    r = idle_row(); r.mwe = 1'b1; r.mdat = 8'h02; r.set = 1'b1; drive(r);
    @(negedge clk); irq_req = 8'h02;
    @(posedge clk); #2;
    check("R4 held request presented", {irq_valid, irq_vector}, {1'b1, 8'd4});
    @(negedge clk); irq_ack = 1'b1;
    @(posedge clk); #2; irq_ack = 1'b0;
    check("R5 accept while held", {irq_valid, gie}, 32'd0);
    @(negedge clk); reti = 1'b1;
    @(posedge clk); #2; reti = 1'b0; irq_req = '0;
    check("R4 re-pended request after return", {irq_valid, irq_vector, gie}, {1'b1, 8'd4, 1'b1});

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
      $finish;
    end
  end
endmodule